// File: doc/BRIEF.md
# Configurable TDM Codec Frame Generator

This block sequences the serial framing of a time-division-multiplexed audio codec port. Every cycle of `clk` stands for one serial bit clock. While the port is enabled, the block steps through a frame of 1 to 32 time slots. It marks the frame start, the start of each slot, the current slot number, and the window in which a slot carries data bits. One output lane shifts out a parallel word per slot, most significant bit first.

Slot 0 may use its own length, and all other slots share one common length. The number of data bits placed in a slot is set apart from the slot length. All sizes are chosen from small encoded sets. The configuration is held in registers that can only be changed while the port is disabled. A mode code is stored beside the framing fields and presented to the mode-specific logic that sits outside this block.

Top module: `tdm_frame_gen`

## Requirements
- R1: After reset, every configuration field reads 0. The outputs `frame_sync`, `slot_start`, `data_valid` and `sdata` are 0, and `slot_idx` and `mode` are 0. With this all-zero configuration, an enabled port runs frames of one slot lasting 8 clocks, carrying 8 data bits.
- R2: A slot count code n on `cfg_slots` gives n+1 slots per frame. `slot_idx` takes the values 0, 1, ..., n and then wraps to 0, and it stays constant across the clocks of one slot.
- R3: Every slot other than slot 0 lasts a number of clocks set by `cfg_slot_len`: 0=8, 1=16, 2=18, 3=20, 4=24, 5=32. `slot_start` is 1 on the first clock of each slot and 0 on every other clock.
- R4: Slot 0 lasts a number of clocks set by `cfg_slot0_len`: 0 means the same as the other slots, 1=8, 2=16, 3=32.
- R5: `cfg_bits` selects the data bits per slot: 0=8, 1=16, 2=18, 3=20, 4=24, 5=32. `data_valid` is 1 on the first min(data bits, slot length) clocks of each slot and 0 on the rest.
- R6: At the first clock of each slot, the block samples `tx_word`. It then sends that word's low `data bits` bits on `sdata`, most significant first, so bit k of the slot carries word bit (data bits − 1 − k). `sdata` is 0 whenever `data_valid` is 0.
- R7: `frame_sync` is 1 for exactly one clock, the first clock of slot 0, in every frame.
- R8: A write pulse on `cfg_we` stores all five fields only if `port_en` is 0 at that edge. While `port_en` is 1, writes leave the framing and `mode` unchanged.
- R9: Reserved codes 6 and 7 of `cfg_slot_len` and `cfg_bits` act as the 32 setting.
- R10: The stored 3-bit mode code (0..7) appears on `mode` from the cycle after the accepted write.
- R11: While `port_en` is 0, the framing outputs are 0 from the next edge on and the sequence returns to slot 0, clock 0. The first clock of slot 0 appears at the edge that first samples `port_en` as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one cycle per bit |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Runs the sequencer; also locks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slots | input | 5 | Slot count code (slots = code + 1) |
| cfg_mode | input | 3 | Port mode code |
| cfg_slot_len | input | 3 | Length code for slots other than 0 |
| cfg_slot0_len | input | 2 | Length code for slot 0 |
| cfg_bits | input | 3 | Data bits per slot code |
| tx_word | input | 32 | Parallel word sampled at each slot start |
| frame_sync | output | 1 | First clock of slot 0 |
| slot_start | output | 1 | First clock of any slot |
| slot_idx | output | 5 | Current slot number |
| data_valid | output | 1 | Data window within the slot |
| sdata | output | 1 | Serial data, MSB first |
| mode | output | 3 | Stored mode code |

## Verification
All framing outputs and `sdata` are registered. The position that the counters hold at an edge appears on the outputs just after that edge. The bench therefore drives `port_en` high on a falling edge and expects clock 0 of slot 0 at the next falling edge, and then one new position per cycle. A configuration write is launched on a falling edge and shows on `mode` one cycle later. `tx_word` is set on the falling edge before a slot's first clock, and it is scrambled at every other position, so that a design that samples the word late is caught. Disabling shows idle outputs at the falling edge one cycle after `port_en` drops.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int CNT_W = 6;

  typedef struct packed {
    logic [4:0] slots;
    logic [2:0] mode;
    logic [2:0] slot_len;
    logic [1:0] slot0_len;
    logic [2:0] bits;
  } tdm_cfg_t;

  // shared decode for slot length and data bits; reserved codes map to 32
  function automatic logic [CNT_W-1:0] dec_size(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(16);
      3'd2:    return CNT_W'(18);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] dec_first(input logic [1:0] code,
                                                 input logic [CNT_W-1:0] other);
    case (code)
      2'd0:    return other;
      2'd1:    return CNT_W'(8);
      2'd2:    return CNT_W'(16);
      default: return CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
  import tdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     port_en,
  input  logic     wr_en,
  input  tdm_cfg_t wr_cfg,
  output tdm_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)                  cfg <= '0;
    else if (wr_en && !port_en) cfg <= wr_cfg;
  end

  // R8
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && port_en) |=> $stable(cfg));
endmodule

// File: rtl/tdm_sequencer.sv
module tdm_sequencer
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  tdm_cfg_t          cfg,
  output logic              load_word,
  output logic              bit_active,
  output logic [CNT_W-1:0]  nbits,
  output logic              frame_sync,
  output logic              slot_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              data_valid
);
  logic [SLOT_W-1:0] cur_slot;
  logic [CNT_W-1:0]  cur_bit;
  logic [CNT_W-1:0]  len_other, len_first, cur_len, act_len;
  logic              end_slot, end_frame;

  always_comb begin
    len_other  = dec_size(cfg.slot_len);
    len_first  = dec_first(cfg.slot0_len, len_other);
    cur_len    = (cur_slot == '0) ? len_first : len_other;
    nbits      = dec_size(cfg.bits);
    act_len    = (nbits < cur_len) ? nbits : cur_len;
    end_slot   = (cur_bit == CNT_W'(cur_len - CNT_W'(1)));
    end_frame  = (cur_slot == SLOT_W'(cfg.slots));
    load_word  = port_en && (cur_bit == '0);
    bit_active = (cur_bit < act_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      cur_slot   <= '0;
      cur_bit    <= '0;
      frame_sync <= 1'b0;
      slot_start <= 1'b0;
      slot_idx   <= '0;
      data_valid <= 1'b0;
    end else begin
      frame_sync <= (cur_slot == '0) && (cur_bit == '0);
      slot_start <= (cur_bit == '0);
      slot_idx   <= cur_slot;
      data_valid <= bit_active;
      if (end_slot) begin
        cur_bit  <= '0;
        cur_slot <= end_frame ? '0 : SLOT_W'(cur_slot + SLOT_W'(1));
      end else begin
        cur_bit <= CNT_W'(cur_bit + CNT_W'(1));
      end
    end
  end

  // R7
  sync_slot0_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (slot_start && slot_idx == '0));
  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> (slot_idx <= SLOT_W'(cfg.slots)));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !frame_sync) |-> (slot_idx == SLOT_W'($past(slot_idx) + SLOT_W'(1))));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!frame_sync && !slot_start && !data_valid));
  // R5
  valid_start_chk: assert property (@(posedge clk) disable iff (rst)
    slot_start |-> data_valid);
endmodule

// File: rtl/tdm_lane_shift.sv
module tdm_lane_shift
  import tdm_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              load_word,
  input  logic              bit_active,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdata
);
  logic [WORD_W-1:0] shreg, aligned;

  always_comb aligned = tx_word << (WORD_W - int'(nbits));

  always_ff @(posedge clk) begin
    if (rst || !port_en) begin
      shreg <= '0;
      sdata <= 1'b0;
    end else if (load_word) begin
      sdata <= bit_active & aligned[WORD_W-1];
      shreg <= aligned << 1;
    end else begin
      sdata <= bit_active & shreg[WORD_W-1];
      shreg <= shreg << 1;
    end
  end
endmodule

// File: rtl/tdm_frame_gen.sv
module tdm_frame_gen
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_slots,
  input  logic [2:0]        cfg_mode,
  input  logic [2:0]        cfg_slot_len,
  input  logic [1:0]        cfg_slot0_len,
  input  logic [2:0]        cfg_bits,
  input  logic [WORD_W-1:0] tx_word,
  output logic              frame_sync,
  output logic              slot_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              data_valid,
  output logic              sdata,
  output logic [2:0]        mode
);
  tdm_cfg_t         wr_cfg, cfg;
  logic             load_word, bit_active;
  logic [CNT_W-1:0] nbits;

  always_comb begin
    wr_cfg.slots     = cfg_slots;
    wr_cfg.mode      = cfg_mode;
    wr_cfg.slot_len  = cfg_slot_len;
    wr_cfg.slot0_len = cfg_slot0_len;
    wr_cfg.bits      = cfg_bits;
  end

  assign mode = cfg.mode;

  tdm_cfg_regs u_regs (
    .clk(clk), .rst(rst), .port_en(port_en), .wr_en(cfg_we),
    .wr_cfg(wr_cfg), .cfg(cfg)
  );

  tdm_sequencer #(.SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst(rst), .port_en(port_en), .cfg(cfg),
    .load_word(load_word), .bit_active(bit_active), .nbits(nbits),
    .frame_sync(frame_sync), .slot_start(slot_start),
    .slot_idx(slot_idx), .data_valid(data_valid)
  );

  tdm_lane_shift #(.WORD_W(WORD_W)) u_lane (
    .clk(clk), .rst(rst), .port_en(port_en), .load_word(load_word),
    .bit_active(bit_active), .nbits(nbits), .tx_word(tx_word),
    .sdata(sdata)
  );

  // R6
  quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> !sdata);
endmodule

// File: tb/tdm_frame_gen_test.sv
`timescale 1ns/1ps
module tdm_frame_gen_test;
  logic        clk = 1'b0;
  logic        rst, port_en, cfg_we;
  logic [4:0]  cfg_slots;
  logic [2:0]  cfg_mode, cfg_slot_len, cfg_bits;
  logic [1:0]  cfg_slot0_len;
  logic [31:0] tx_word;
  logic        frame_sync, slot_start, data_valid, sdata;
  logic [4:0]  slot_idx;
  logic [2:0]  mode;
  int checks = 0, errors = 0, seed = 0;

  always #2 clk = ~clk;

  tdm_frame_gen uut (
    .clk(clk), .rst(rst), .port_en(port_en), .cfg_we(cfg_we),
    .cfg_slots(cfg_slots), .cfg_mode(cfg_mode), .cfg_slot_len(cfg_slot_len),
    .cfg_slot0_len(cfg_slot0_len), .cfg_bits(cfg_bits), .tx_word(tx_word),
    .frame_sync(frame_sync), .slot_start(slot_start), .slot_idx(slot_idx),
    .data_valid(data_valid), .sdata(sdata), .mode(mode)
  );

  function automatic int size_of(input int code);
    int tbl[6] = '{8, 16, 18, 20, 24, 32};
    return (code < 6) ? tbl[code] : 32;  // R9 reserved -> 32
  endfunction

  function automatic int first_len(input int code, input int other);
    int tbl[4] = '{0, 8, 16, 32};
    return (code == 0) ? other : tbl[code];
  endfunction

  function automatic logic [31:0] word_for(input int s);
    return 32'hC3A5_1E69 ^ (32'(s) * 32'h0101_0F37) ^ (32'(seed) * 32'h9E37_79B9);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int sl, input int md, input int ln, input int s0, input int bt);
    @(negedge clk);
    cfg_slots = 5'(sl); cfg_mode = 3'(md); cfg_slot_len = 3'(ln);
    cfg_slot0_len = 2'(s0); cfg_bits = 3'(bt); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // enable and compare every position of nfr frames against the model
  task automatic run_frames(input int sl, input int ln, input int s0, input int bt, input int nfr);
    int lo, l0, nb;
    lo = size_of(ln); l0 = first_len(s0, lo); nb = size_of(bt);
    seed++;
    tx_word = word_for(0);
    port_en = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s <= sl; s++) begin
        int len, actl;
        logic [31:0] w;
        len = (s == 0) ? l0 : lo;
        actl = (nb < len) ? nb : len;
        w = word_for(s);
        for (int b = 0; b < len; b++) begin
          logic dv, sd;
          @(negedge clk);
          dv = (b < actl);
          sd = dv ? w[nb-1-b] : 1'b0;
          check("R7 frame_sync", 32'(frame_sync), 32'(s == 0 && b == 0));
          check("R2 slot_idx", 32'(slot_idx), 32'(s));
          if (s == 0) check("R4 slot_start", 32'(slot_start), 32'(b == 0));
          else        check("R3 slot_start", 32'(slot_start), 32'(b == 0));
          check("R5 data_valid", 32'(data_valid), 32'(dv));
          check("R6 sdata", 32'(sdata), 32'(sd));
          if (b == len - 1) tx_word = word_for((s == sl) ? 0 : s + 1);
          else              tx_word = ~tx_word;
        end
      end
    end
  endtask

  task automatic stop_port;
    port_en = 1'b0;
    @(negedge clk);
    check("R11 idle frame_sync", 32'(frame_sync), 0);
    check("R11 idle slot_start", 32'(slot_start), 0);
    check("R11 idle data_valid", 32'(data_valid), 0);
    check("R11 idle sdata", 32'(sdata), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; port_en = 1'b0; cfg_we = 1'b0; tx_word = '0;
    cfg_slots = '0; cfg_mode = '0; cfg_slot_len = '0; cfg_slot0_len = '0; cfg_bits = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 frame_sync", 32'(frame_sync), 0);
    check("R1 slot_start", 32'(slot_start), 0);
    check("R1 slot_idx", 32'(slot_idx), 0);
    check("R1 data_valid", 32'(data_valid), 0);
    check("R1 sdata", 32'(sdata), 0);
    check("R1 mode", 32'(mode), 0);
    // R1 default configuration: one 8-clock slot, 8 bits
    run_frames(0, 0, 0, 0, 3);
    stop_port();

    // R3 R4 R5 R9 sweep over every length, first-length and bit code
    for (int ln = 0; ln < 8; ln++)
      for (int s0 = 0; s0 < 4; s0++)
        for (int bt = 0; bt < 8; bt++) begin
          write_cfg(2, (ln + bt) % 8, ln, s0, bt);
          check("R10 mode", 32'(mode), 32'((ln + bt) % 8));
          run_frames(2, ln, s0, bt, 2);
          stop_port();
        end

    // R2 full 32-slot frame and wrap
    write_cfg(31, 4, 0, 3, 5);
    run_frames(31, 0, 3, 5, 2);
    stop_port();

    // R8 writes while enabled are ignored
    write_cfg(1, 5, 0, 0, 0);
    check("R10 mode", 32'(mode), 5);
    cfg_slots = 5'd7; cfg_mode = 3'd2; cfg_slot_len = 3'd5; cfg_bits = 3'd5;
    cfg_we = 1'b1;
    run_frames(1, 0, 0, 0, 3);
    check("R8 mode locked", 32'(mode), 5);
    cfg_we = 1'b0;
    stop_port();
    // R11 restart begins at slot 0 clock 0; R8 write accepted when disabled
    run_frames(1, 0, 0, 0, 1);
    stop_port();
    write_cfg(7, 2, 5, 0, 5);
    check("R8 mode written", 32'(mode), 2);
    run_frames(7, 5, 0, 5, 1);
    stop_port();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule